// File: doc/BRIEF.md
# SD Command Issue and Status Unit

This block is the register-facing command engine of a simple SD host. Software loads an argument word, an optional timeout start value, and then a 16-bit command word. A command word written with its launch bit set starts a command on the card side. The launch bit stays set while the command is in flight and drops when the command has finished. Software polls that bit to learn that the command is over. A separate fail bit in the same word reports an error ending, and the cause is also recorded in a status register.

The card side is abstract. A done strobe means that the response arrived, or, for a command that expects no response, that the command was sent. It comes with a 128-bit response and a CRC7 error flag. A busy level is released by the card after a busy-wait command. While the engine waits for the strobe, a down-counter loaded from the timeout start value runs, and reaching zero ends the command with a timeout. Sticky status bits are set by the engine and by data-path event inputs, and software clears them by writing ones.

Register addresses on the 3-bit word address: 0 command, 1 argument, 2 timeout start, 3 to 6 response words 0 to 3, 7 status. Every register reads back on `reg_rdata_o` in the same cycle as its address.

Top module: `sd_cmd_engine`

## Requirements
- R1: The command word holds the index in bits 5:0, read-data in bit 6, write-data in bit 7, long response in bit 9, no response in bit 10, busy-wait in bit 11, fail in bit 14 and launch in bit 15, and bits 8, 12 and 13 read as zero. A write to address 0 with bit 15 set while no command is in flight launches a command. `card_start_o` pulses for one cycle, the cycle after the write, and the index and argument are presented on the card outputs.
- R2: After a completing done strobe, bit 15 of the command word reads zero from the next cycle on. This holds for a short or long response command without busy-wait, and for any no-response command.
- R3: A command-word write that arrives while bit 15 is set has no effect on the command word.
- R4: Launch loads the counter with the timeout start value (address 2). If no done strobe arrives, the command ends S+1 cycles after the launch edge, where S is the start value: bit 15 clears, fail (bit 14) sets, and status bit 6 sets. A done strobe in the very cycle the counter is zero completes the command normally.
- R5: A done strobe with CRC7 error on a command expecting a response ends it with fail set, bit 15 clear, status bit 4 set, and no response captured.
- R6: A long response writes all four response registers, with register 0 holding bits 31:0 of the response and register 3 holding bits 127:96. A short response writes register 0 only and leaves registers 1 to 3 unchanged.
- R7: A no-response command ignores the CRC7 flag, captures nothing, and completes on the done strobe.
- R8: A response command with busy-wait keeps bit 15 set after its done strobe until `card_busy_i` is low at a clock edge. At that edge bit 15 clears and status bit 10 sets.
- R9: Status bits 3 to 10 are sticky. Writing a one to one of these bits clears it, and writing zero leaves it as it is. A hardware set in the same cycle as a clear wins.
- R10: The data-path inputs set status bit 3 (FIFO error), bit 5 (CRC16 error), bit 7 (read/write timeout), bit 8 (SDIO event) and bit 9 (block event). Status bit 0 shows the live data-flag input.
- R11: Reset clears every register to zero and leaves no command in flight.
- R12: A launch clears the fail bit, whatever value software writes to bit 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 3 | Register word address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| card_start_o | output | 1 | One-cycle command launch pulse |
| card_index_o | output | 6 | Command index of the current command |
| card_arg_o | output | 32 | Command argument |
| card_long_o | output | 1 | Current command expects a long response |
| card_noresp_o | output | 1 | Current command expects no response |
| card_done_i | input | 1 | Response received, or command sent when no response is expected |
| card_resp_i | input | 128 | Response bits, valid with card_done_i |
| card_crc7_err_i | input | 1 | Response CRC7 error, valid with card_done_i |
| card_busy_i | input | 1 | Card busy level |
| dp_data_flag_i | input | 1 | Live data flag from the data path |
| dp_fifo_err_i | input | 1 | FIFO error event |
| dp_crc16_err_i | input | 1 | Data CRC16 error event |
| dp_rw_tmo_i | input | 1 | Read/write timeout event |
| dp_sdio_ev_i | input | 1 | SDIO event |
| dp_block_ev_i | input | 1 | Block event |

## Verification
A software write-one clear of a status bit and a hardware set of that same bit can land on one clock edge. The bench holds a data-path event high in the cycle that writes a one to that bit, then reads status back and expects the bit still set. A second race is a done strobe against counter expiry. The strobe is placed exactly in the zero-count cycle, where it must complete the command with no fail, and then one cycle later, where the timeout must already have won. A behavioural model follows every register on each clock, so a wrong priority shows up at once in the read data.

// File: rtl/sd_cmd_pkg.sv
`timescale 1ns/1ps
package sd_cmd_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned RESP_WORDS = 4;
  localparam int unsigned ADDR_W     = 3;
  localparam int unsigned CMD_W      = 16;
  localparam int unsigned IDX_W      = 6;
  localparam int unsigned ST_W       = 11;

  // command word bit positions
  localparam int unsigned C_LONG  = 9;
  localparam int unsigned C_NORSP = 10;
  localparam int unsigned C_BUSY  = 11;
  localparam int unsigned C_FAIL  = 14;
  localparam int unsigned C_NEW   = 15;
  localparam logic [CMD_W-1:0] CMD_KEEP     = 16'h0EFF;
  localparam logic [CMD_W-1:0] CMD_NEW_MASK = 16'h8000;

  // status bit positions
  localparam int unsigned S_DATA  = 0;
  localparam int unsigned S_FIFO  = 3;
  localparam int unsigned S_CRC7  = 4;
  localparam int unsigned S_CRC16 = 5;
  localparam int unsigned S_CTMO  = 6;
  localparam int unsigned S_RWTMO = 7;
  localparam int unsigned S_SDIO  = 8;
  localparam int unsigned S_BLOCK = 9;
  localparam int unsigned S_BUSYE = 10;
  localparam logic [ST_W-1:0] ST_STICKY = 11'h7F8;

  localparam logic [ADDR_W-1:0] A_CMD   = 3'd0;
  localparam logic [ADDR_W-1:0] A_ARG   = 3'd1;
  localparam logic [ADDR_W-1:0] A_TMO   = 3'd2;
  localparam logic [ADDR_W-1:0] A_RESP0 = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd7;

  typedef enum logic [1:0] {EN_IDLE, EN_WAIT, EN_BUSY} eng_state_e;
endpackage

// File: rtl/sd_cmd_fsm.sv
`timescale 1ns/1ps
module sd_cmd_fsm
  import sd_cmd_pkg::*;
#(
  parameter int unsigned TMO_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  logic [CMD_W-1:0] cmd_word_i,
  input  logic [TMO_W-1:0] tmo_start_i,
  input  logic             card_done_i,
  input  logic             card_crc7_err_i,
  input  logic             card_busy_i,
  output logic [CMD_W-1:0] cmd_o,
  output logic             start_o,
  output logic             cap_o,
  output logic             set_crc7_o,
  output logic             set_tmo_o,
  output logic             set_busy_o
);
  eng_state_e       state_q;
  logic [TMO_W-1:0] tmo_q;
  logic [CMD_W-1:0] cmd_q;
  logic             start_q;
  logic             in_wait, want_rsp, rsp_ok;

  assign in_wait    = (state_q == EN_WAIT);
  assign want_rsp   = !cmd_q[C_NORSP];
  assign rsp_ok     = in_wait && card_done_i && !(want_rsp && card_crc7_err_i);
  assign cap_o      = rsp_ok && want_rsp;
  assign set_crc7_o = in_wait && card_done_i && want_rsp && card_crc7_err_i;
  // done wins over expiry in the same cycle
  assign set_tmo_o  = in_wait && !card_done_i && (tmo_q == '0);
  assign set_busy_o = (state_q == EN_BUSY) && !card_busy_i;
  assign cmd_o      = cmd_q;
  assign start_o    = start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= EN_IDLE;
      tmo_q   <= '0;
      cmd_q   <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= launch_i;
      if (launch_i) begin
        cmd_q   <= (cmd_word_i & CMD_KEEP) | CMD_NEW_MASK;
        tmo_q   <= tmo_start_i;
        state_q <= EN_WAIT;
      end else begin
        case (state_q)
          EN_WAIT: begin
            if (rsp_ok) begin
              if (want_rsp && cmd_q[C_BUSY]) begin
                state_q <= EN_BUSY;
              end else begin
                cmd_q[C_NEW] <= 1'b0;
                state_q      <= EN_IDLE;
              end
            end else if (set_crc7_o || set_tmo_o) begin
              cmd_q[C_NEW]  <= 1'b0;
              cmd_q[C_FAIL] <= 1'b1;
              state_q       <= EN_IDLE;
            end else begin
              tmo_q <= tmo_q - TMO_W'(1);
            end
          end
          EN_BUSY: begin
            if (set_busy_o) begin
              cmd_q[C_NEW] <= 1'b0;
              state_q      <= EN_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  p_done_clears_new_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_wait && card_done_i && !launch_i && (cmd_q[C_NORSP] || !cmd_q[C_BUSY]))
      |=> !cmd_q[C_NEW]);

  p_timeout_fails_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_wait && !card_done_i && (tmo_q == '0)) |=> (cmd_q[C_FAIL] && !cmd_q[C_NEW]));

  p_crc7_fails_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_wait && card_done_i && card_crc7_err_i && !cmd_q[C_NORSP])
      |=> (cmd_q[C_FAIL] && !cmd_q[C_NEW]));

  p_busy_holds_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == EN_BUSY) && card_busy_i) |=> cmd_q[C_NEW]);

  p_launch_clears_fail_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |=> (start_q && !cmd_q[C_FAIL] && cmd_q[C_NEW]));
endmodule

// File: rtl/sd_resp_regs.sv
`timescale 1ns/1ps
module sd_resp_regs #(
  parameter int unsigned DW = 32,
  parameter int unsigned NW = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cap_i,
  input  logic                  long_i,
  input  logic [NW*DW-1:0]      resp_i,
  output logic [NW-1:0][DW-1:0] resp_o
);
  logic [NW-1:0][DW-1:0] resp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_q <= '0;
    end else if (cap_i) begin
      for (int i = 0; i < int'(NW); i++) begin
        if (long_i || i == 0) resp_q[i] <= resp_i[i*DW +: DW];
      end
    end
  end

  assign resp_o = resp_q;

  p_short_keeps_upper_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && !long_i) |=> (resp_q[NW-1:1] == $past(resp_q[NW-1:1])));

  p_long_low_word_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && long_i) |=> (resp_q[0] == $past(resp_i[DW-1:0])));
endmodule

// File: rtl/sd_status_reg.sv
`timescale 1ns/1ps
module sd_status_reg
  import sd_cmd_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [ST_W-1:0] set_i,
  input  logic [ST_W-1:0] clr_i,
  input  logic            data_flag_i,
  output logic [ST_W-1:0] status_o
);
  logic [ST_W-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= ((st_q & ~clr_i) | set_i) & ST_STICKY;
  end

  always_comb begin
    status_o         = st_q;
    status_o[S_DATA] = data_flag_i;
  end

  p_w1c_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~set_i & ST_STICKY)) |=> ((st_q & $past(clr_i & ~set_i & ST_STICKY)) == '0));

  p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(set_i & ST_STICKY)) |=> ((st_q & $past(set_i & ST_STICKY)) == $past(set_i & ST_STICKY)));
endmodule

// File: rtl/sd_cmd_engine.sv
`timescale 1ns/1ps
module sd_cmd_engine
  import sd_cmd_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [ADDR_W-1:0]      reg_addr_i,
  input  logic                   reg_we_i,
  input  logic [DW-1:0]          reg_wdata_i,
  output logic [DW-1:0]          reg_rdata_o,
  output logic                   card_start_o,
  output logic [IDX_W-1:0]       card_index_o,
  output logic [DW-1:0]          card_arg_o,
  output logic                   card_long_o,
  output logic                   card_noresp_o,
  input  logic                   card_done_i,
  input  logic [RESP_WORDS*DW-1:0] card_resp_i,
  input  logic                   card_crc7_err_i,
  input  logic                   card_busy_i,
  input  logic                   dp_data_flag_i,
  input  logic                   dp_fifo_err_i,
  input  logic                   dp_crc16_err_i,
  input  logic                   dp_rw_tmo_i,
  input  logic                   dp_sdio_ev_i,
  input  logic                   dp_block_ev_i
);
  logic [DW-1:0]                 arg_q, tmo_start_q;
  logic [CMD_W-1:0]              cmd_q;
  logic [RESP_WORDS-1:0][DW-1:0] resp_q;
  logic [ST_W-1:0]               st_set, st_clr, status;
  logic cmd_wr, launch, start, cap, set_crc7, set_tmo, set_busy;

  assign cmd_wr = reg_we_i && (reg_addr_i == A_CMD);
  assign launch = cmd_wr && reg_wdata_i[C_NEW] && !cmd_q[C_NEW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arg_q       <= '0;
      tmo_start_q <= '0;
    end else if (reg_we_i) begin
      if (reg_addr_i == A_ARG) arg_q       <= reg_wdata_i;
      if (reg_addr_i == A_TMO) tmo_start_q <= reg_wdata_i;
    end
  end

  sd_cmd_fsm #(.TMO_W(DW)) u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .launch_i       (launch),
    .cmd_word_i     (reg_wdata_i[CMD_W-1:0]),
    .tmo_start_i    (tmo_start_q),
    .card_done_i    (card_done_i),
    .card_crc7_err_i(card_crc7_err_i),
    .card_busy_i    (card_busy_i),
    .cmd_o          (cmd_q),
    .start_o        (start),
    .cap_o          (cap),
    .set_crc7_o     (set_crc7),
    .set_tmo_o      (set_tmo),
    .set_busy_o     (set_busy)
  );

  sd_resp_regs #(.DW(DW), .NW(RESP_WORDS)) u_resp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cap_i (cap),
    .long_i(cmd_q[C_LONG]),
    .resp_i(card_resp_i),
    .resp_o(resp_q)
  );

  always_comb begin
    st_set          = '0;
    st_set[S_FIFO]  = dp_fifo_err_i;
    st_set[S_CRC7]  = set_crc7;
    st_set[S_CRC16] = dp_crc16_err_i;
    st_set[S_CTMO]  = set_tmo;
    st_set[S_RWTMO] = dp_rw_tmo_i;
    st_set[S_SDIO]  = dp_sdio_ev_i;
    st_set[S_BLOCK] = dp_block_ev_i;
    st_set[S_BUSYE] = set_busy;
    st_clr = (reg_we_i && reg_addr_i == A_STAT) ? reg_wdata_i[ST_W-1:0] : '0;
  end

  sd_status_reg u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (st_set),
    .clr_i      (st_clr),
    .data_flag_i(dp_data_flag_i),
    .status_o   (status)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CMD:  reg_rdata_o[CMD_W-1:0] = cmd_q;
      A_ARG:  reg_rdata_o = arg_q;
      A_TMO:  reg_rdata_o = tmo_start_q;
      A_STAT: reg_rdata_o[ST_W-1:0] = status;
      default: begin
        for (int i = 0; i < int'(RESP_WORDS); i++) begin
          if (int'(reg_addr_i) == int'(A_RESP0) + i) reg_rdata_o = resp_q[i];
        end
      end
    endcase
  end

  assign card_start_o  = start;
  assign card_index_o  = cmd_q[IDX_W-1:0];
  assign card_arg_o    = arg_q;
  assign card_long_o   = cmd_q[C_LONG];
  assign card_noresp_o = cmd_q[C_NORSP];

  p_ignore_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && cmd_q[C_NEW]) |=> (cmd_q[CMD_W-3:0] == $past(cmd_q[CMD_W-3:0])));

  p_start_follows_launch_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_start_o |-> $past(launch));
endmodule

// File: tb/sd_cmd_engine_tb_top.sv
`timescale 1ns/1ps
module sd_cmd_engine_tb_top;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [2:0]   reg_addr_i = '0;
  logic         reg_we_i = 1'b0;
  logic [31:0]  reg_wdata_i = '0;
  logic [31:0]  reg_rdata_o;
  logic         card_start_o, card_long_o, card_noresp_o;
  logic [5:0]   card_index_o;
  logic [31:0]  card_arg_o;
  logic         card_done_i = 1'b0;
  logic [127:0] card_resp_i = '0;
  logic         card_crc7_err_i = 1'b0;
  logic         card_busy_i = 1'b0;
  logic         dp_data_flag_i = 1'b0, dp_fifo_err_i = 1'b0, dp_crc16_err_i = 1'b0;
  logic         dp_rw_tmo_i = 1'b0, dp_sdio_ev_i = 1'b0, dp_block_ev_i = 1'b0;

  always #2.5 clk_i = ~clk_i;

  sd_cmd_engine dut_i (.*);

  int  checks = 0;
  int  fails  = 0;
  bit  finished = 1'b0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // behavioural reference model
  logic [15:0] m_cmd;
  logic [31:0] m_arg, m_ts;
  int unsigned m_cnt;
  logic [31:0] m_resp [4];
  logic [10:0] m_st;
  int          m_mode;  // 0 idle, 1 awaiting done, 2 awaiting busy release
  bit          m_start;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cmd = '0; m_arg = '0; m_ts = '0; m_cnt = 0; m_st = '0; m_mode = 0; m_start = 0;
      for (int i = 0; i < 4; i++) m_resp[i] = '0;
    end else begin
      logic [10:0] sets;
      bit go;
      sets = '0;
      sets[3] = dp_fifo_err_i; sets[5] = dp_crc16_err_i; sets[7] = dp_rw_tmo_i;
      sets[8] = dp_sdio_ev_i;  sets[9] = dp_block_ev_i;
      go = reg_we_i && reg_addr_i == 3'd0 && reg_wdata_i[15] && !m_cmd[15];
      m_start = go;
      if (go) begin
        m_cmd = (reg_wdata_i[15:0] & 16'h0EFF) | 16'h8000;
        m_cnt = m_ts; m_mode = 1;
      end else if (m_mode == 1) begin
        if (card_done_i) begin
          if (m_cmd[10]) begin
            m_cmd[15] = 0; m_mode = 0;
          end else if (card_crc7_err_i) begin
            m_cmd[15] = 0; m_cmd[14] = 1; sets[4] = 1; m_mode = 0;
          end else begin
            m_resp[0] = card_resp_i[31:0];
            if (m_cmd[9]) begin
              m_resp[1] = card_resp_i[63:32];
              m_resp[2] = card_resp_i[95:64];
              m_resp[3] = card_resp_i[127:96];
            end
            if (m_cmd[11]) m_mode = 2;
            else begin m_cmd[15] = 0; m_mode = 0; end
          end
        end else if (m_cnt == 0) begin
          m_cmd[15] = 0; m_cmd[14] = 1; sets[6] = 1; m_mode = 0;
        end else m_cnt--;
      end else if (m_mode == 2 && !card_busy_i) begin
        m_cmd[15] = 0; sets[10] = 1; m_mode = 0;
      end
      if (reg_we_i && reg_addr_i == 3'd1) m_arg = reg_wdata_i;
      if (reg_we_i && reg_addr_i == 3'd2) m_ts = reg_wdata_i;
      if (reg_we_i && reg_addr_i == 3'd7) m_st = m_st & ~reg_wdata_i[10:0];
      m_st = (m_st | sets) & 11'h7F8;
    end
  end

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return {16'h0, m_cmd};
      3'd1: return m_arg;
      3'd2: return m_ts;
      3'd7: return {21'h0, m_st | {10'h0, dp_data_flag_i}};
      default: return m_resp[a - 3'd3];
    endcase
  endfunction

  // per-cycle comparison, between the negative edge and the next rising edge
  always @(negedge clk_i) begin
    #1.5;
    if (rst_ni && !finished) begin
      case (reg_addr_i)
        3'd0:       chk("R2 model cmd word", reg_rdata_o, m_read(reg_addr_i));
        3'd1, 3'd2: chk("R1 model arg/timeout", reg_rdata_o, m_read(reg_addr_i));
        3'd7:       chk("R9 model status", reg_rdata_o, m_read(reg_addr_i));
        default:    chk("R6 model response", reg_rdata_o, m_read(reg_addr_i));
      endcase
      chk("R1 model start pulse", {31'h0, card_start_o}, {31'h0, m_start});
      chk("R1 model index", {26'h0, card_index_o}, {26'h0, m_cmd[5:0]});
      chk("R1 model arg out", card_arg_o, m_arg);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_we_i = 1'b1; reg_wdata_i = d;
    @(posedge clk_i); #0.5;
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_we_i = 1'b0;
    #1.5 d = reg_rdata_o;
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic done_after(input int n, input logic [127:0] r, input logic crc);
    repeat (n) @(posedge clk_i);
    #0.5;
    card_done_i = 1'b1; card_resp_i = r; card_crc7_err_i = crc;
    @(posedge clk_i); #0.5;
    card_done_i = 1'b0; card_crc7_err_i = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // R11: reset state
    for (int a = 0; a < 8; a++) begin rd(3'(a), d); chk("R11 reset value", d, 32'h0); end

    // R1 / R3 / R2 / R6: short response
    wr(3'd1, 32'hA5A5_0001);
    wr(3'd2, 32'd100);
    wr(3'd0, 32'h0000_8011);
    chk("R1 start pulse", {31'h0, card_start_o}, 32'h1);
    chk("R1 index out", {26'h0, card_index_o}, 32'h11);
    chk("R1 arg out", card_arg_o, 32'hA5A5_0001);
    wr(3'd0, 32'h0000_8005);
    rd(3'd0, d); chk("R3 write while busy ignored", d, 32'h8011);
    done_after(1, {32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111}, 1'b0);
    rd(3'd0, d); chk("R2 launch bit cleared", d, 32'h0011);
    rd(3'd3, d); chk("R6 short word0", d, 32'h1111_1111);
    rd(3'd4, d); chk("R6 short leaves word1", d, 32'h0);

    // R6: long response
    wr(3'd0, 32'h0000_8202);
    done_after(1, {32'hDDDD_0004, 32'hCCCC_0003, 32'hBBBB_0002, 32'hAAAA_0001}, 1'b0);
    rd(3'd0, d); chk("R2 long done", d, 32'h0202);
    rd(3'd3, d); chk("R6 long word0 low bits", d, 32'hAAAA_0001);
    rd(3'd4, d); chk("R6 long word1", d, 32'hBBBB_0002);
    rd(3'd5, d); chk("R6 long word2", d, 32'hCCCC_0003);
    rd(3'd6, d); chk("R6 long word3 high bits", d, 32'hDDDD_0004);
    wr(3'd0, 32'h0000_800D);
    done_after(1, {4{32'h5555_5555}}, 1'b0);
    rd(3'd3, d); chk("R6 short after long word0", d, 32'h5555_5555);
    rd(3'd6, d); chk("R6 short after long word3 kept", d, 32'hDDDD_0004);

    // R7: no response ignores CRC7 and captures nothing
    wr(3'd0, 32'h0000_8400);
    done_after(1, {4{32'hEEEE_EEEE}}, 1'b1);
    rd(3'd0, d); chk("R7 no-response done", d, 32'h0400);
    rd(3'd3, d); chk("R7 no capture", d, 32'h5555_5555);
    rd(3'd7, d); chk("R7 no status", d, 32'h0);

    // R4: timeout after S+1 cycles
    wr(3'd2, 32'd5);
    wr(3'd0, 32'h0000_8008);
    repeat (5) @(posedge clk_i);
    peek(3'd0, d); chk("R4 still pending at S", d, 32'h8008);
    @(posedge clk_i);
    peek(3'd0, d); chk("R4 timeout fail", d, 32'h4008);
    rd(3'd7, d); chk("R4 timeout status", d, 32'h40);
    wr(3'd7, 32'h0);
    rd(3'd7, d); chk("R9 write zero keeps", d, 32'h40);
    wr(3'd7, 32'h40);
    rd(3'd7, d); chk("R9 write one clears", d, 32'h0);

    // R12: fail cleared on launch, written fail bit dropped
    wr(3'd2, 32'd100);
    wr(3'd0, 32'h0000_C009);
    peek(3'd0, d); chk("R12 fail cleared on launch", d, 32'h8009);
    done_after(1, '0, 1'b0);
    rd(3'd0, d); chk("R12 completes clean", d, 32'h0009);

    // R4: done exactly on the expiry cycle, then one cycle late
    wr(3'd2, 32'd3);
    wr(3'd0, 32'h0000_8003);
    done_after(3, {4{32'h0123_4567}}, 1'b0);
    rd(3'd0, d); chk("R4 done at expiry wins", d, 32'h0003);
    rd(3'd7, d); chk("R4 no timeout status", d, 32'h0);
    wr(3'd0, 32'h0000_8003);
    done_after(4, {4{32'h7654_3210}}, 1'b0);
    rd(3'd0, d); chk("R4 late done loses", d, 32'h4003);
    rd(3'd7, d); chk("R4 late timeout status", d, 32'h40);
    rd(3'd3, d); chk("R4 late done no capture", d, 32'h0123_4567);
    wr(3'd7, 32'h7F8);

    // R5: CRC7 error
    wr(3'd0, 32'h0000_8004);
    done_after(1, {4{32'h9999_9999}}, 1'b1);
    rd(3'd0, d); chk("R5 crc7 fail", d, 32'h4004);
    rd(3'd7, d); chk("R5 crc7 status", d, 32'h10);
    rd(3'd3, d); chk("R5 no capture", d, 32'h0123_4567);
    wr(3'd7, 32'h10);

    // R8: busy wait
    card_busy_i = 1'b1;
    wr(3'd0, 32'h0000_8807);
    done_after(1, {4{32'h0BAD_CAFE}}, 1'b0);
    repeat (6) @(posedge clk_i);
    peek(3'd0, d); chk("R8 held while busy", d, 32'h8807);
    @(negedge clk_i); card_busy_i = 1'b0;
    @(posedge clk_i);
    peek(3'd0, d); chk("R8 release completes", d, 32'h0807);
    peek(3'd7, d); chk("R8 busy event", d, 32'h400);
    wr(3'd7, 32'h400);

    // R9: set wins over clear in the same cycle
    @(negedge clk_i);
    reg_addr_i = 3'd7; reg_we_i = 1'b1; reg_wdata_i = 32'h8; dp_fifo_err_i = 1'b1;
    @(posedge clk_i); #0.5;
    reg_we_i = 1'b0; dp_fifo_err_i = 1'b0;
    peek(3'd7, d); chk("R9 set wins over clear", d, 32'h8);

    // R10: data path events and live flag
    @(negedge clk_i);
    dp_crc16_err_i = 1'b1; dp_rw_tmo_i = 1'b1; dp_sdio_ev_i = 1'b1; dp_block_ev_i = 1'b1;
    @(posedge clk_i); #0.5;
    dp_crc16_err_i = 1'b0; dp_rw_tmo_i = 1'b0; dp_sdio_ev_i = 1'b0; dp_block_ev_i = 1'b0;
    peek(3'd7, d); chk("R10 sticky events", d, 32'h3A8);
    dp_data_flag_i = 1'b1;
    peek(3'd7, d); chk("R10 live flag high", d, 32'h3A9);
    dp_data_flag_i = 1'b0;
    peek(3'd7, d); chk("R10 live flag low", d, 32'h3A8);

    // R11: reset mid-command
    wr(3'd2, 32'd50);
    wr(3'd0, 32'h0000_8001);
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    for (int a = 0; a < 8; a++) begin rd(3'(a), d); chk("R11 reset mid command", d, 32'h0); end
    chk("R11 no start after reset", {31'h0, card_start_o}, 32'h0);

    repeat (2) @(posedge clk_i);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule